// File: doc/BRIEF.md
# Reorder Buffer with Deferred Register Release

This block is a circular reorder buffer that stores, for each dispatched instruction, the physical register it writes and the physical register that mapping replaced. Retirement only moves the commit pointer. The replaced register is not returned to the free list at that moment. A third pointer, the release point, trails the commit pointer. Between the release point and the commit pointer sit retired entries whose fields are still intact.

Because those fields remain readable, a rename stage can ask for the destination register of the instruction a given distance back from the youngest dispatch. The answer stays valid whether that instruction is still in flight or has recently retired. The block uses this to share a producer's register with a later consumer.

Registers are handed back in batches. A batch is released only under pressure: when the free list runs low, or when dispatch is about to wrap onto the release point. A flush moves the dispatch pointer back and leaves the commit pointer and the release point where they are.

Top module: `lazy_rob`

## Requirements
- R1: After reset, `disp_ready` is 1, `disp_index` is 0, no `rcl_valid` lane is set, and every lookup returns `lk_valid` 0 with `lk_preg` 0.
- R2: An accepted dispatch writes its two register fields at the slot shown on `disp_index` before the edge. The slot then advances by one, and slot DEPTH-1 is followed by slot 0.
- R3: Distance d counts back from the youngest dispatch, so d=1 is the last one dispatched. The lookup returns `lk_valid` 1 and that entry's new register when 1 <= d <= the number of entries from the release point up to the dispatch slot. Any other d, including 0, returns `lk_valid` 0 and `lk_preg` 0.
- R4: Commit retires the oldest in-flight entry. Commit by itself sets no `rcl_valid` lane, and a retired entry remains visible to lookups until it is released.
- R5: A commit with no in-flight entry is ignored. A later release therefore frees only entries that really retired.
- R6: Release is triggered when `fl_count` <= 2*RENAME_W, or when the occupied entries (release point to dispatch slot) number at least DEPTH-NEAR_FULL. With neither condition, `rcl_valid` is 0.
- R7: While triggered, the block emits the old register of min(LANES, retired count) of the oldest retired entries. Lane 0 holds the oldest, and lanes are filled from 0 upward. It never passes the commit pointer. On the edge the release point advances by that count, and the released entries become lookup-invalid.
- R8: When all DEPTH slots are occupied, `disp_ready` is 0, a dispatch request is dropped, and `disp_index` does not move.
- R9: A flush sets the dispatch slot to `flush_tail` and discards the younger in-flight entries. It outranks a dispatch or commit in the same cycle, and leaves the commit pointer and the release point unchanged.
- R10: If release and dispatch fall in one cycle, `disp_ready` is decided on the occupancy at the start of that cycle. Slots freed by the release are usable from the next cycle.
- R11: `rcl_valid` and `rcl_preg` are combinational from the current state and `fl_count`, and are valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_new_preg | input | PREG_W | Destination physical register of the dispatched instruction |
| disp_old_preg | input | PREG_W | Physical register previously mapped to that destination |
| disp_ready | output | 1 | A free slot exists this cycle |
| disp_index | output | $clog2(DEPTH) | Slot the next dispatch will use |
| commit_valid | input | 1 | Retire the oldest in-flight entry |
| flush_valid | input | 1 | Roll the dispatch slot back |
| flush_tail | input | $clog2(DEPTH) | New dispatch slot on flush |
| lk_dist | input | $clog2(DEPTH+1) | Lookup distance back from the youngest dispatch |
| lk_valid | output | 1 | Lookup hit a valid entry |
| lk_preg | output | PREG_W | Destination register of the looked-up entry |
| fl_count | input | FLC_W | Current number of free physical registers |
| rcl_valid | output | LANES | Per-lane release valid |
| rcl_preg | output | LANES*PREG_W | Released registers, lane k in bits k*PREG_W upward |

## Verification
Release and dispatch can fall in the same cycle. The bench provokes this by filling every slot and committing one entry. In the next cycle the near-full trigger releases that entry while a dispatch is requested. The dispatch must be refused in that cycle, with the freed slot taken on the following one. After that, a lookup at the maximum distance must show the surviving older entry, not the overwritten one.

Release and commit also share cycles. The bench issues surplus commits on an empty window and then forces a release, to confirm that only truly retired entries come out.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the deferred-release reorder buffer.
// Assumes every offset passed in is smaller than the ring depth.
package rob_pkg;

    // Reason a release batch is being emitted.
    typedef enum logic [1:0] {
        RCL_IDLE      = 2'd0,
        RCL_LOW_FREE  = 2'd1,
        RCL_NEAR_FULL = 2'd2
    } rcl_cause_e;

    // Forward step on a ring of the given depth.
    function automatic int unsigned ring_step(int unsigned base, int unsigned offs,
                                              int unsigned depth);
        int unsigned s;
        s = base + offs;
        return (s >= depth) ? s - depth : s;
    endfunction

    // Backward step on a ring of the given depth.
    function automatic int unsigned ring_back(int unsigned base, int unsigned offs,
                                              int unsigned depth);
        return (base >= offs) ? base - offs : base + depth - offs;
    endfunction

endpackage

// File: rtl/rob_store.sv
`timescale 1ns/1ps
// Entry storage: one write port for dispatch, one read port for lookups and
// LANES consecutive read ports starting at the release point.
// Contents are not reset; the control logic decides which slots are valid.
module rob_store #(
    parameter int DEPTH  = 192,
    parameter int PREG_W = 8,
    parameter int LANES  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [PREG_W-1:0]       wr_new,
    input  logic [PREG_W-1:0]       wr_old,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [PREG_W-1:0]       rd_new,
    input  logic [IDX_W-1:0]        rcl_base,
    output logic [LANES*PREG_W-1:0] rcl_old
);
    import rob_pkg::*;

    logic [PREG_W-1:0] new_mem [DEPTH];
    logic [PREG_W-1:0] old_mem [DEPTH];

    // Capture both register fields of a dispatched instruction.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            new_mem[wr_idx] <= wr_new;
            old_mem[wr_idx] <= wr_old;
        end
    end

    assign rd_new = new_mem[rd_idx];

    // One read lane per release slot, walking forward from the release point.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IDX_W-1:0] lane_idx;
        assign lane_idx = IDX_W'(ring_step(32'(rcl_base), k, DEPTH));
        assign rcl_old[k*PREG_W +: PREG_W] = old_mem[lane_idx];
    end

endmodule

// File: rtl/rob_ptrs.sv
`timescale 1ns/1ps
// Pointer and occupancy control: dispatch slot, commit pointer, release point,
// with in-flight and retired counts. Flush outranks dispatch and commit.
// Assumes flush_idx lies within the current in-flight window.
module rob_ptrs #(
    parameter int DEPTH  = 192,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_req,
    input  logic             commit_req,
    input  logic             flush_req,
    input  logic [IDX_W-1:0] flush_idx,
    input  logic [CNT_W-1:0] rcl_cnt,
    output logic [IDX_W-1:0] tail,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] rel,
    output logic [CNT_W-1:0] used,
    output logic [CNT_W-1:0] retired,
    output logic             disp_acc
);
    import rob_pkg::*;

    logic [IDX_W-1:0] tail_q, head_q, rel_q;
    logic [CNT_W-1:0] inflight_q, retired_q;
    logic             com_acc;

    assign used     = inflight_q + retired_q;
    assign disp_acc = disp_req && !flush_req && (used != CNT_W'(DEPTH));
    assign com_acc  = commit_req && !flush_req && (inflight_q != '0);

    // Advance the three pointers and keep both counts in step with them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q     <= '0;
            head_q     <= '0;
            rel_q      <= '0;
            inflight_q <= '0;
            retired_q  <= '0;
        end else begin
            rel_q     <= IDX_W'(ring_step(32'(rel_q), 32'(rcl_cnt), DEPTH));
            retired_q <= retired_q + CNT_W'(com_acc) - rcl_cnt;
            if (com_acc) head_q <= IDX_W'(ring_step(32'(head_q), 1, DEPTH));
            if (flush_req) begin
                tail_q     <= flush_idx;
                inflight_q <= CNT_W'(ring_back(32'(flush_idx), 32'(head_q), DEPTH));
            end else begin
                if (disp_acc) tail_q <= IDX_W'(ring_step(32'(tail_q), 1, DEPTH));
                inflight_q <= inflight_q + CNT_W'(disp_acc) - CNT_W'(com_acc);
            end
        end
    end

    assign tail    = tail_q;
    assign head    = head_q;
    assign rel     = rel_q;
    assign retired = retired_q;

endmodule

// File: rtl/rob_reclaim.sv
`timescale 1ns/1ps
// Release trigger and batch sizing. Combinational: the batch is visible in the
// cycle it is decided, and the pointer control consumes the count at the edge.
module rob_reclaim #(
    parameter int DEPTH     = 192,
    parameter int LANES     = 8,
    parameter int RENAME_W  = 4,
    parameter int NEAR_FULL = 2,
    parameter int FLC_W     = 9,
    localparam int CNT_W    = $clog2(DEPTH+1)
) (
    input  logic [CNT_W-1:0] used,
    input  logic [CNT_W-1:0] retired,
    input  logic [FLC_W-1:0] fl_count,
    output logic [CNT_W-1:0] rcl_cnt,
    output logic [LANES-1:0] rcl_mask
);
    import rob_pkg::*;

    localparam logic [FLC_W-1:0] FL_LOW    = FLC_W'(2 * RENAME_W);
    localparam logic [CNT_W-1:0] FULL_MARK = CNT_W'(DEPTH - NEAR_FULL);
    localparam logic [CNT_W-1:0] LANE_CAP  = CNT_W'(LANES);

    rcl_cause_e cause;

    // Pick the release cause; free-list pressure is checked first.
    always_comb begin
        if (fl_count <= FL_LOW)      cause = RCL_LOW_FREE;
        else if (used >= FULL_MARK)  cause = RCL_NEAR_FULL;
        else                         cause = RCL_IDLE;
    end

    // Batch size is capped by the lane count and by the retired entries.
    always_comb begin
        if (cause == RCL_IDLE)       rcl_cnt = '0;
        else if (retired >= LANE_CAP) rcl_cnt = LANE_CAP;
        else                         rcl_cnt = retired;
    end

    // Lanes fill from 0 upward.
    for (genvar k = 0; k < LANES; k++) begin : g_mask
        assign rcl_mask[k] = (CNT_W'(k) < rcl_cnt);
    end

endmodule

// File: rtl/lazy_rob.sv
`timescale 1ns/1ps
// Reorder buffer with deferred register release. Retired entries stay readable
// for distance lookups until a pressure-triggered batch releases them.
// Assumes the caller never flushes outside the in-flight window.
module lazy_rob #(
    parameter int DEPTH     = 192,
    parameter int PREG_W    = 8,
    parameter int LANES     = 8,
    parameter int RENAME_W  = 4,
    parameter int NEAR_FULL = 2,
    parameter int FLC_W     = 9,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH+1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    disp_valid,
    input  logic [PREG_W-1:0]       disp_new_preg,
    input  logic [PREG_W-1:0]       disp_old_preg,
    output logic                    disp_ready,
    output logic [IDX_W-1:0]        disp_index,
    input  logic                    commit_valid,
    input  logic                    flush_valid,
    input  logic [IDX_W-1:0]        flush_tail,
    input  logic [CNT_W-1:0]        lk_dist,
    output logic                    lk_valid,
    output logic [PREG_W-1:0]       lk_preg,
    input  logic [FLC_W-1:0]        fl_count,
    output logic [LANES-1:0]        rcl_valid,
    output logic [LANES*PREG_W-1:0] rcl_preg
);
    import rob_pkg::*;

    logic [IDX_W-1:0]  tail_w, head_w, rel_w, lk_idx;
    logic [CNT_W-1:0]  used_w, retired_w, rcl_cnt_w;
    logic              disp_acc_w;
    logic [PREG_W-1:0] rd_new_w;
    logic [LANES*PREG_W-1:0] rcl_old_w;

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .disp_req(disp_valid), .commit_req(commit_valid),
        .flush_req(flush_valid), .flush_idx(flush_tail), .rcl_cnt(rcl_cnt_w),
        .tail(tail_w), .head(head_w), .rel(rel_w), .used(used_w),
        .retired(retired_w), .disp_acc(disp_acc_w)
    );

    rob_reclaim #(.DEPTH(DEPTH), .LANES(LANES), .RENAME_W(RENAME_W),
                  .NEAR_FULL(NEAR_FULL), .FLC_W(FLC_W)) u_rcl (
        .used(used_w), .retired(retired_w), .fl_count(fl_count),
        .rcl_cnt(rcl_cnt_w), .rcl_mask(rcl_valid)
    );

    rob_store #(.DEPTH(DEPTH), .PREG_W(PREG_W), .LANES(LANES)) u_store (
        .clk(clk), .wr_en(disp_acc_w), .wr_idx(tail_w), .wr_new(disp_new_preg),
        .wr_old(disp_old_preg), .rd_idx(lk_idx), .rd_new(rd_new_w),
        .rcl_base(rel_w), .rcl_old(rcl_old_w)
    );

    // Resolve the lookup distance against the occupied window.
    assign lk_idx   = IDX_W'(ring_back(32'(tail_w), 32'(lk_dist), DEPTH));
    assign lk_valid = (lk_dist != '0) && (lk_dist <= used_w);
    assign lk_preg  = lk_valid ? rd_new_w : '0;

    // Show only the lanes that carry a released register.
    for (genvar k = 0; k < LANES; k++) begin : g_out
        assign rcl_preg[k*PREG_W +: PREG_W] =
            rcl_valid[k] ? rcl_old_w[k*PREG_W +: PREG_W] : '0;
    end

    assign disp_ready = (used_w != CNT_W'(DEPTH));
    assign disp_index = tail_w;

endmodule

// File: rtl/rob_chk.sv
`timescale 1ns/1ps
// Property checker for lazy_rob, attached by bind to its ports and pointer state.
module rob_chk #(
    parameter int DEPTH     = 192,
    parameter int LANES     = 8,
    parameter int RENAME_W  = 4,
    parameter int NEAR_FULL = 2,
    parameter int FLC_W     = 9,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH+1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [IDX_W-1:0] disp_index,
    input logic             commit_valid,
    input logic             flush_valid,
    input logic [IDX_W-1:0] flush_tail,
    input logic [CNT_W-1:0] lk_dist,
    input logic             lk_valid,
    input logic [FLC_W-1:0] fl_count,
    input logic [LANES-1:0] rcl_valid,
    input logic [CNT_W-1:0] used,
    input logic [CNT_W-1:0] retired,
    input logic [IDX_W-1:0] head
);
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready && !flush_valid) |=> $stable(disp_index));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        used <= CNT_W'(DEPTH));

    assert_flush_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> disp_index == $past(flush_tail));

    assert_flush_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> head == $past(head));

    assert_idle_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_count > FLC_W'(2*RENAME_W) && used < CNT_W'(DEPTH-NEAR_FULL)) |-> rcl_valid == '0);

    assert_stop_at_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'($countones(rcl_valid)) <= retired);

    assert_lanes_packed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rcl_valid + 1'b1) & rcl_valid) == '0);

    assert_dist_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_dist == '0 |-> !lk_valid);

    assert_empty_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !flush_valid && used == retired) |=> head == $past(head));

endmodule

bind lazy_rob rob_chk #(
    .DEPTH(DEPTH), .LANES(LANES), .RENAME_W(RENAME_W),
    .NEAR_FULL(NEAR_FULL), .FLC_W(FLC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_index(disp_index), .commit_valid(commit_valid), .flush_valid(flush_valid),
    .flush_tail(flush_tail), .lk_dist(lk_dist), .lk_valid(lk_valid),
    .fl_count(fl_count), .rcl_valid(rcl_valid), .used(used_w),
    .retired(retired_w), .head(head_w)
);

// File: tb/sim_lazy_rob.sv
`timescale 1ns/1ps
// Bench for lazy_rob: a vector table for basic dispatch/commit/lookup, then
// directed cases for release, empty commit, flush, wrap, stall and collisions.
module sim_lazy_rob;
    localparam int DEPTH = 192, PREG_W = 8, LANES = 8, FLC_W = 9;
    localparam int IDX_W = $clog2(DEPTH), CNT_W = $clog2(DEPTH+1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic disp_valid = 1'b0, disp_ready;
    logic [PREG_W-1:0] disp_new_preg = '0, disp_old_preg = '0, lk_preg;
    logic [IDX_W-1:0] disp_index, flush_tail = '0;
    logic commit_valid = 1'b0, flush_valid = 1'b0, lk_valid;
    logic [CNT_W-1:0] lk_dist = '0;
    logic [FLC_W-1:0] fl_count = 9'd100;
    logic [LANES-1:0] rcl_valid;
    logic [LANES*PREG_W-1:0] rcl_preg;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    lazy_rob u0 (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_new_preg(disp_new_preg),
        .disp_old_preg(disp_old_preg), .disp_ready(disp_ready), .disp_index(disp_index),
        .commit_valid(commit_valid), .flush_valid(flush_valid), .flush_tail(flush_tail),
        .lk_dist(lk_dist), .lk_valid(lk_valid), .lk_preg(lk_preg), .fl_count(fl_count),
        .rcl_valid(rcl_valid), .rcl_preg(rcl_preg)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic int lane(input int k);
        return int'(rcl_preg[k*PREG_W +: PREG_W]);
    endfunction

    // Row: op(2) a(8) b(8) exp_valid(1) exp_value(8); op 0 dispatch, 1 commit, 2 lookup.
    localparam int NROW = 15;
    localparam logic [26:0] TBL [NROW] = '{
        {2'd0, 8'd10, 8'd50, 1'b1, 8'd0}, {2'd0, 8'd11, 8'd51, 1'b1, 8'd1},
        {2'd0, 8'd12, 8'd52, 1'b1, 8'd2}, {2'd0, 8'd13, 8'd53, 1'b1, 8'd3},
        {2'd0, 8'd14, 8'd54, 1'b1, 8'd4}, {2'd0, 8'd15, 8'd55, 1'b1, 8'd5},
        {2'd2, 8'd1,  8'd0,  1'b1, 8'd15}, {2'd2, 8'd6,  8'd0,  1'b1, 8'd10},
        {2'd2, 8'd7,  8'd0,  1'b0, 8'd0},  {2'd2, 8'd0,  8'd0,  1'b0, 8'd0},
        {2'd1, 8'd0,  8'd0,  1'b0, 8'd0},  {2'd1, 8'd0,  8'd0,  1'b0, 8'd0},
        {2'd1, 8'd0,  8'd0,  1'b0, 8'd0},  {2'd2, 8'd6,  8'd0,  1'b1, 8'd10},
        {2'd2, 8'd3,  8'd0,  1'b1, 8'd13}
    };

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        lk_dist = 8'd1;
        #1;
        check("R1 ready", int'(disp_ready), 1);
        check("R1 index", int'(disp_index), 0);
        check("R1 release", int'(rcl_valid), 0);
        check("R1 lookup", int'(lk_valid), 0);
        @(negedge clk); rst_n = 1'b1;

        // Table walk: dispatch six, look up, commit three, look up retired.
        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            disp_valid = 1'b0; commit_valid = 1'b0;
            case (TBL[r][26:25])
                2'd0: begin disp_valid = 1'b1; disp_new_preg = TBL[r][24:17];
                            disp_old_preg = TBL[r][16:9]; end
                2'd1: commit_valid = 1'b1;
                default: lk_dist = TBL[r][24:17];
            endcase
            #1;
            if (TBL[r][26:25] == 2'd0)
                check("R2 slot", int'(disp_index), int'(TBL[r][7:0]));
            if (TBL[r][26:25] == 2'd2) begin
                check("R3 hit", int'(lk_valid), int'(TBL[r][8]));
                check("R3 preg", int'(lk_preg), int'(TBL[r][7:0]));
            end
            check("R4 no release on commit", int'(rcl_valid), 0);
        end
        @(negedge clk); disp_valid = 1'b0; commit_valid = 1'b0;

        // Free-list trigger boundary and batch contents (R6, R7, R11).
        fl_count = 9'd9; #1;
        check("R6 above threshold", int'(rcl_valid), 0);
        fl_count = 9'd8; #1;
        check("R6 R11 lanes", int'(rcl_valid), 7);
        check("R7 lane0", lane(0), 50);
        check("R7 lane1", lane(1), 51);
        check("R7 lane2", lane(2), 52);
        @(negedge clk); fl_count = 9'd100; lk_dist = 8'd6; #1;
        check("R7 released invalid", int'(lk_valid), 0);
        lk_dist = 8'd3; #1;
        check("R7 survivor", int'(lk_preg), 13);

        // Five commits, only three real (R5).
        commit_valid = 1'b1;
        repeat (5) @(negedge clk);
        commit_valid = 1'b0; fl_count = 9'd8; #1;
        check("R5 lanes", int'(rcl_valid), 7);
        check("R5 lane2", lane(2), 55);
        @(negedge clk); fl_count = 9'd100; lk_dist = 8'd1; #1;
        check("R7 window empty", int'(lk_valid), 0);

        // Flush beats a same-cycle dispatch (R9).
        for (int k = 0; k < 4; k++) begin
            disp_valid = 1'b1; disp_new_preg = 8'(20 + k); disp_old_preg = 8'(60 + k);
            @(negedge clk);
        end
        flush_valid = 1'b1; flush_tail = 8'd8; disp_new_preg = 8'd99;
        @(negedge clk); flush_valid = 1'b0; disp_valid = 1'b0; lk_dist = 8'd1; #1;
        check("R9 slot", int'(disp_index), 8);
        check("R9 youngest", int'(lk_preg), 21);
        lk_dist = 8'd3; #1;
        check("R9 discarded", int'(lk_valid), 0);

        // Fill with wrap (R2) until full, then stall (R8).
        for (int k = 0; k < 190; k++) begin
            disp_valid = 1'b1; disp_new_preg = 8'(k); disp_old_preg = 8'(k + 100); #1;
            check("R2 wrap slot", int'(disp_index), (8 + k) % DEPTH);
            @(negedge clk);
        end
        disp_new_preg = 8'd200; #1;
        check("R8 ready low", int'(disp_ready), 0);
        check("R7 none retired", int'(rcl_valid), 0);
        @(negedge clk); #1;
        check("R8 slot held", int'(disp_index), 6);

        // Commit one; next cycle release and dispatch collide (R10).
        disp_valid = 1'b0; commit_valid = 1'b1;
        @(negedge clk); commit_valid = 1'b0; disp_valid = 1'b1; #1;
        check("R10 ready low", int'(disp_ready), 0);
        check("R6 near-full lane", int'(rcl_valid), 1);
        check("R10 released preg", lane(0), 60);
        @(negedge clk); disp_new_preg = 8'd77; disp_old_preg = 8'd88; #1;
        check("R10 ready next", int'(disp_ready), 1);
        check("R10 slot", int'(disp_index), 6);
        @(negedge clk); disp_valid = 1'b0; lk_dist = 8'd1; #1;
        check("R10 new entry", int'(lk_preg), 77);
        lk_dist = 8'd192; #1;
        check("R3 farthest", int'(lk_preg), 21);
        lk_dist = 8'd193; #1;
        check("R3 beyond", int'(lk_valid), 0);

        finish_run();
    end
endmodule